// File: doc/BRIEF.md
# Decimal Matrix Check-Bit Encoder

This block computes the redundancy that is stored next to a memory word so that a later decoder can locate and repair clusters of flipped cells. The data word is cut into 4-bit symbols and arranged as a matrix of two rows with four symbols each. Symbol k is the bit field `[4k+3:4k]`, so symbols 0 to 3 form the low row and symbols 4 to 7 form the high row.

Two kinds of check bits come out. The horizontal checks are integer sums, not parity. Within each row, a symbol is added to the symbol two columns to its right. Each sum is kept at full width, so its carry is part of the stored value. The vertical checks are the column-wise XOR of the low row and the high row. The 32 data bits, 20 horizontal bits and 16 vertical bits together make a 68-bit stored entry.

A strobe marks each word to be encoded. The output stage can be built as a register loaded on that strobe, or as a plain combinational path. The widths follow from the symbol width and the number of columns.

Top module: `matrix_check_encoder`

## Requirements
- R1: The data word is split into symbols of 4 bits, symbol k being `in_data[4k+3:4k]` for k = 0..7. Symbols 0..3 form the low row and 4..7 the high row; symbol k sits in column k mod 4.
- R2: `out_hchk[4:0]` is the 5-bit unsigned sum of symbol 0 and symbol 2, and `out_hchk[9:5]` is the 5-bit unsigned sum of symbol 1 and symbol 3. Bit 4 of each group holds the carry.
- R3: `out_hchk[14:10]` is symbol 4 plus symbol 6, and `out_hchk[19:15]` is symbol 5 plus symbol 7. No 5-bit group ever exceeds 30.
- R4: `out_vchk` equals `in_data[15:0] ^ in_data[31:16]`.
- R5: `out_data` carries the encoded word unchanged.
- R6: With the output register built (REG_OUT=1, the default), the data and check outputs show the word presented with `in_valid` high one clock later. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high.
- R7: In the registered build, a cycle with `in_valid` low changes none of `out_data`, `out_hchk` or `out_vchk`, whatever `in_data` holds, and `out_valid` is low in the following cycle.
- R8: While `rst_n` is low, `out_valid`, `out_data`, `out_hchk` and `out_vchk` are all zero.
- R9: An all-zero word gives all-zero check bits. An all-ones word gives 5'b11110 in every horizontal group and zero vertical checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Marks a word to encode; acts as the register load enable |
| in_data | input | 32 | Word to be protected |
| out_valid | output | 1 | Marks valid data and check outputs |
| out_data | output | 32 | Encoded word, passed through |
| out_hchk | output | 20 | Four 5-bit horizontal symbol-pair sums |
| out_vchk | output | 16 | Column XOR of the two matrix rows |

## Verification
The assertions assume that `in_valid` and `in_data` are settled at each rising edge. They also assume that `in_valid` stays low while reset is applied, because the strobe-to-valid latency is checked against the previous cycle. The bench changes all inputs on the falling edge and keeps the strobe low whenever `rst_n` is low, including around the mid-run reset. Random words are mixed with saturated symbols, so carries into bit 4 of each sum occur often.

// File: rtl/dmc_enc_pkg.sv
package dmc_enc_pkg;
  // Default matrix geometry: two rows of four 4-bit symbols.
  localparam int unsigned SYM_W_DEF  = 4;
  localparam int unsigned N_COLS_DEF = 4;
  localparam int unsigned N_ROWS     = 2;

  // Largest value one horizontal group can take.
  function automatic int unsigned max_pair_sum(input int unsigned sym_w);
    return 2 * ((1 << sym_w) - 1);
  endfunction
endpackage

// File: rtl/dmc_pair_adder.sv
module dmc_pair_adder #(
  parameter int unsigned SYM_W = 4,
  localparam int unsigned SUM_W = SYM_W + 1
) (
  input  logic [SYM_W-1:0] a_sym,
  input  logic [SYM_W-1:0] b_sym,
  output logic [SUM_W-1:0] sum_o
);
  // Full-width sum keeps the carry, so it cannot wrap.
  always_comb begin
    sum_o = {1'b0, a_sym} + {1'b0, b_sym};
  end
endmodule

// File: rtl/dmc_row_fold.sv
module dmc_row_fold #(
  parameter int unsigned ROW_W = 16
) (
  input  logic [2*ROW_W-1:0] word_i,
  output logic [ROW_W-1:0]   fold_o
);
  always_comb begin
    fold_o = word_i[ROW_W-1:0] ^ word_i[2*ROW_W-1:ROW_W];
  end
endmodule

// File: rtl/matrix_check_encoder.sv
module matrix_check_encoder #(
  parameter int unsigned SYM_W   = dmc_enc_pkg::SYM_W_DEF,
  parameter int unsigned N_COLS  = dmc_enc_pkg::N_COLS_DEF,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned ROW_W  = SYM_W * N_COLS,
  localparam int unsigned DATA_W = dmc_enc_pkg::N_ROWS * ROW_W,
  localparam int unsigned SUM_W  = SYM_W + 1,
  localparam int unsigned HALF   = N_COLS / 2,
  localparam int unsigned N_GRP  = dmc_enc_pkg::N_ROWS * HALF,
  localparam int unsigned H_W    = N_GRP * SUM_W,
  localparam int unsigned V_W    = ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [H_W-1:0]    out_hchk,
  output logic [V_W-1:0]    out_vchk
);
  logic [H_W-1:0] enc_h;
  logic [V_W-1:0] enc_v;

  // Horizontal checks: inside each row, column c pairs with column c+HALF.
  for (genvar r = 0; r < dmc_enc_pkg::N_ROWS; r++) begin : g_row
    for (genvar c = 0; c < HALF; c++) begin : g_pair
      localparam int unsigned GRP = r * HALF + c;
      localparam int unsigned LO  = r * N_COLS + c;
      localparam int unsigned HI  = LO + HALF;
      dmc_pair_adder #(.SYM_W(SYM_W)) u_add (
        .a_sym (in_data[LO*SYM_W +: SYM_W]),
        .b_sym (in_data[HI*SYM_W +: SYM_W]),
        .sum_o (enc_h[GRP*SUM_W +: SUM_W])
      );
    end
  end

  // Vertical checks: column-wise XOR of the two rows.
  dmc_row_fold #(.ROW_W(ROW_W)) u_fold (
    .word_i (in_data),
    .fold_o (enc_v)
  );

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] dat_q, dat_d;
    logic [H_W-1:0]    h_q, h_d;
    logic [V_W-1:0]    v_q, v_d;

    // Next state: load on strobe, otherwise hold.
    always_comb begin
      dat_d = dat_q;
      h_d   = h_q;
      v_d   = v_q;
      if (in_valid) begin
        dat_d = in_data;
        h_d   = enc_h;
        v_d   = enc_v;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
        h_q   <= '0;
        v_q   <= '0;
      end else begin
        vld_q <= in_valid;
        dat_q <= dat_d;
        h_q   <= h_d;
        v_q   <= v_d;
      end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
    assign out_hchk  = h_q;
    assign out_vchk  = v_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_data  = in_data;
    assign out_hchk  = enc_h;
    assign out_vchk  = enc_v;
  end
endmodule

// File: rtl/dmc_enc_chk.sv
module dmc_enc_chk #(
  parameter int unsigned SYM_W   = 4,
  parameter int unsigned N_COLS  = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned ROW_W  = SYM_W * N_COLS,
  localparam int unsigned DATA_W = 2 * ROW_W,
  localparam int unsigned SUM_W  = SYM_W + 1,
  localparam int unsigned HALF   = N_COLS / 2,
  localparam int unsigned N_GRP  = 2 * HALF,
  localparam int unsigned H_W    = N_GRP * SUM_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [H_W-1:0]    out_hchk,
  input logic [ROW_W-1:0]  out_vchk
);
  localparam int unsigned MAX_SUM = dmc_enc_pkg::max_pair_sum(SYM_W);

  // Vertical checks agree with the word shown beside them.
  p_vfold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_vchk == (out_data[ROW_W-1:0] ^ out_data[DATA_W-1:ROW_W]));

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int unsigned LO = (g / HALF) * N_COLS + (g % HALF);
    localparam int unsigned HI = LO + HALF;
    // R2 / R3: each group is the sum of its symbol pair in out_data.
    p_pair_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(out_hchk[g*SUM_W +: SUM_W]) ==
      int'(out_data[LO*SYM_W +: SYM_W]) + int'(out_data[HI*SYM_W +: SYM_W]));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(out_hchk[g*SUM_W +: SUM_W]) <= int'(MAX_SUM));
  end

  if (REG_OUT) begin : g_seq
    p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    p_data_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_data == $past(in_data));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data) &&
                     $stable(out_hchk) && $stable(out_vchk)));
  end
endmodule

bind matrix_check_encoder dmc_enc_chk #(
  .SYM_W(SYM_W), .N_COLS(N_COLS), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data),
  .out_hchk(out_hchk), .out_vchk(out_vchk)
);

// File: tb/matrix_check_encoder_tb.sv
module matrix_check_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [19:0] out_hchk;
  logic [15:0] out_vchk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Model of the registered outputs.
  logic [31:0] m_data = '0;

  always #10 clk = ~clk;

  matrix_check_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_hchk(out_hchk), .out_vchk(out_vchk)
  );

  function automatic logic [3:0] sym(input logic [31:0] d, input int k);
    return d[4*k +: 4];
  endfunction

  function automatic logic [19:0] ref_h(input logic [31:0] d);
    logic [19:0] h;
    h[4:0]   = 5'(sym(d,0)) + 5'(sym(d,2));
    h[9:5]   = 5'(sym(d,1)) + 5'(sym(d,3));
    h[14:10] = 5'(sym(d,4)) + 5'(sym(d,6));
    h[19:15] = 5'(sym(d,5)) + 5'(sym(d,7));
    return h;
  endfunction

  function automatic logic [15:0] ref_v(input logic [31:0] d);
    return d[15:0] ^ d[31:16];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic vld);
    chk(out_valid == vld, {tag, " valid"}, 64'(out_valid), 64'(vld));
    chk(out_data == m_data, {tag, " data"}, 64'(out_data), 64'(m_data));
    chk(out_hchk == ref_h(m_data), {tag, " hchk"}, 64'(out_hchk), 64'(ref_h(m_data)));
    chk(out_vchk == ref_v(m_data), {tag, " vchk"}, 64'(out_vchk), 64'(ref_v(m_data)));
  endtask

  // Called at a falling edge: drive, wait one cycle, compare.
  task automatic apply(input logic [31:0] d, input logic v, input string tag);
    in_data  = d;
    in_valid = v;
    @(negedge clk);
    if (v) m_data = d;
    check_all(tag, v);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R8 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(32'h0000_0000, 1'b1, "R9 zeros");
    chk(out_hchk == 20'h0 && out_vchk == 16'h0, "R9 zero checks",
        {out_hchk, out_vchk}, 64'h0);
    apply(32'hFFFF_FFFF, 1'b1, "R9 ones");
    chk(out_hchk == {4{5'b11110}} && out_vchk == 16'h0, "R9 ones checks",
        {out_hchk, out_vchk}, {{4{5'b11110}}, 16'h0});

    // R2: carry kept in bit 4 of the low groups.
    apply(32'h0000_0F0F, 1'b1, "R2 sat grp0");
    chk(out_hchk[4:0] == 5'd30, "R2 grp0", 64'(out_hchk[4:0]), 64'd30);
    apply(32'h0000_F0F0, 1'b1, "R2 sat grp1");
    chk(out_hchk[9:5] == 5'd30, "R2 grp1", 64'(out_hchk[9:5]), 64'd30);
    // R3: high row pairs.
    apply(32'hF0F0_0000, 1'b1, "R3 sat grp3");
    chk(out_hchk[19:15] == 5'd30 && out_hchk[14:0] == 15'd0, "R3 grp3",
        64'(out_hchk), 64'(20'd30 << 15));

    // R1: one nonzero symbol at a time lands in exactly one group and one V nibble.
    for (int k = 0; k < 8; k++) begin
      apply(32'h9 << (4 * k), 1'b1, "R1 walk");
    end

    // R7: strobe low, changed data must not reach the outputs.
    apply(32'hDEAD_BEEF, 1'b0, "R7 hold a");
    apply(32'h1234_5678, 1'b0, "R7 hold b");

    // R4 R5 R6: random words, some with saturated symbols, random strobe gaps.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom();
      if (i % 5 == 0) d = d | 32'hF0F0_0F0F;
      apply(d, ($urandom() % 4) != 0, "R6 random");
    end

    // R8: reset mid-run with strobe low.
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    m_data = '0;
    check_all("R8 midrun", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    apply(32'hA5C3_3C5A, 1'b1, "R5 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule